// File: doc/BRIEF.md
# Output-Compare Timer

This block is a multi-channel output-compare timer. A free-running up-counter advances by one on every clock while the run bit is set. Each channel holds a compare value and a two-bit action code. When the counter equals a channel's compare value, that channel applies its action to its own output pin and raises its flag. A flag reaches the compare interrupt only if its enable bit is set. When the counter wraps from all ones to zero, the overflow flag is set and can drive a separate interrupt.

Software can fire any channel's action at once through a force register, with no need to wait for a match. The highest-numbered channel is the master channel. When it matches, or when it is forced, it can drive the pins of any lower channels chosen by a mask to levels taken from a data register. The action codes of those channels stay as they are. A flat register port gives write access and combinational read-back.

Top module: `oc_compare_timer`

## Requirements
- R1: Reset (rst_n low) clears the counter, all pins, all flags and both interrupt outputs to 0.
- R2: While CTRL (address 0x00) bit 0 is 1, the counter at address 0x01 rises by exactly one per clock. A write to address 0x01 loads the written value in place of the increment.
- R3: When the running counter steps from 0xFFFF to 0, the overflow flag (address 0x08, bit 0) is set on that edge. irq_ovf equals that flag ANDed with CTRL bit 1. Writing 1 to bit 0 of 0x08 clears the flag, and a new wrap in the same cycle takes priority over the clear.
- R4: Channel n's action code sits in address 0x02, bits 2n+1:2n: 00 leaves the pin alone, 01 toggles it, 10 drives it low, 11 drives it high. The action takes effect on the edge that closes the cycle in which the counter equals the compare register at address 0x10+n.
- R5: A match sets flag n (address 0x06, bit n). Writing 1 to a flag bit clears it, and a match in the same cycle takes priority over the clear. irq_cmp is high while any flag is set whose enable bit (address 0x07, bit n) is also set.
- R6: Writing 1 to bit n of the force register (address 0x03) applies channel n's action on the next edge, the same as a match. A force event sets no flag. The force register reads as 0.
- R7: A master-channel event (a match or a force of the top channel) drives every lower pin n whose mask bit (address 0x04, bit n) is 1 to data bit n (address 0x05). The action register is not changed by this.
- R8: If a lower channel's own event and a master override land on the same pin in the same cycle, the master's data bit wins.
- R9: While the run bit is 0, the counter holds its value, no match occurs, and flags and pins do not change except through force and register writes.
- R10: Every writable register reads back its last written value at its own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |
| oc_pin | output | 8 | Compare output pins, one per channel |
| irq_cmp | output | 1 | Compare interrupt (enabled flags ORed) |
| irq_ovf | output | 1 | Overflow interrupt |

## Verification
Pins, flags, the counter and the overflow flag all change on the rising edge that closes the cycle in which the match, the wrap, the force write or the register write was present. That makes them due exactly one edge after the stimulus. The interrupts and read data are combinational from those registers, so they are valid in the same cycle as the state they reflect. The bench drives each stimulus on a falling edge and advances its reference model once per rising edge. It then compares the pins, both interrupts and one peeked register on the following falling edge, so every expected value lines up with the single register stage on its path.

// File: rtl/oct_pkg.sv
package oct_pkg;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_LOW    = 2'b10,
      ACT_HIGH   = 2'b11
   } oc_act_e;

   localparam logic [4:0] A_CTRL     = 5'h00;
   localparam logic [4:0] A_COUNT    = 5'h01;
   localparam logic [4:0] A_ACTION   = 5'h02;
   localparam logic [4:0] A_FORCE    = 5'h03;
   localparam logic [4:0] A_MASK     = 5'h04;
   localparam logic [4:0] A_DATA     = 5'h05;
   localparam logic [4:0] A_FLAG     = 5'h06;
   localparam logic [4:0] A_IEN      = 5'h07;
   localparam logic [4:0] A_OVF      = 5'h08;
   localparam logic [4:0] A_CMP_BASE = 5'h10;

   function automatic logic apply_action(input oc_act_e act, input logic cur);
      case (act)
         ACT_TOGGLE: apply_action = ~cur;
         ACT_LOW:    apply_action = 1'b0;
         ACT_HIGH:   apply_action = 1'b1;
         default:    apply_action = cur;
      endcase
   endfunction

endpackage

// File: rtl/oct_counter.sv
module oct_counter #(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   input  logic          ovf_clr,
   output logic [CW-1:0] cnt_o,
   output logic          ovf_o
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   logic wrap;
   assign wrap = run && !load && (cnt_o == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_o <= '0;
      else if (load) cnt_o <= load_val;
      else if (run)  cnt_o <= cnt_o + CW'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ovf_o <= 1'b0;
      else if (wrap)    ovf_o <= 1'b1;
      else if (ovf_clr) ovf_o <= 1'b0;
   end
endmodule

// File: rtl/oct_channel.sv
module oct_channel
   import oct_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] cnt,
   input  logic          run,
   input  logic          cmp_we,
   input  logic [CW-1:0] cmp_wd,
   input  logic [1:0]    act,
   input  logic          force_i,
   input  logic          ovr_en,
   input  logic          ovr_val,
   input  logic          flag_clr,
   output logic          match_o,
   output logic          flag_o,
   output logic          pin_o,
   output logic [CW-1:0] cmp_o
);
   logic ev;

   assign match_o = run && (cnt == cmp_o);
   assign ev      = match_o || force_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_o <= '0;
      else if (cmp_we) cmp_o <= cmp_wd;
   end

   // master override sits ahead of the channel's own action (R8)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pin_o <= 1'b0;
      else if (ovr_en) pin_o <= ovr_val;
      else if (ev)     pin_o <= apply_action(oc_act_e'(act), pin_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_o <= 1'b0;
      else if (match_o)  flag_o <= 1'b1;
      else if (flag_clr) flag_o <= 1'b0;
   end
endmodule

// File: rtl/oc_compare_timer.sv
module oc_compare_timer
   import oct_pkg::*;
#(
   parameter int NCH = 8,
   parameter int CW  = 16,
   parameter int DW  = 16,
   parameter int AW  = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bus_we,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [NCH-1:0] oc_pin,
   output logic          irq_cmp,
   output logic          irq_ovf
);
   localparam int MST = NCH - 1;
   localparam int AW_ACT = 2 * NCH;

   if (NCH < 2 || NCH > 16) begin : g_bad_nch
      $error("oc_compare_timer: NCH must lie in 2..16");
   end
   if (AW_ACT > DW || CW > DW) begin : g_bad_dw
      $error("oc_compare_timer: DW too narrow for actions or counter");
   end
   if (AW < 5) begin : g_bad_aw
      $error("oc_compare_timer: AW must be at least 5");
   end

   logic              run_q, ovf_ie_q;
   logic [AW_ACT-1:0] act_q;
   logic [MST-1:0]    mask_q, data_q;
   logic [NCH-1:0]    ien_q;
   logic [CW-1:0]     cnt_q;
   logic              ovf_q;
   logic [NCH-1:0]    match_vec, flag_vec, force_vec;
   logic [CW-1:0]     cmp_arr [NCH];
   logic              master_ev;

   logic we_ctrl, we_count, we_act, we_force, we_mask, we_data, we_flag, we_ien, we_ovf;
   assign we_ctrl  = bus_we && (bus_addr == AW'(A_CTRL));
   assign we_count = bus_we && (bus_addr == AW'(A_COUNT));
   assign we_act   = bus_we && (bus_addr == AW'(A_ACTION));
   assign we_force = bus_we && (bus_addr == AW'(A_FORCE));
   assign we_mask  = bus_we && (bus_addr == AW'(A_MASK));
   assign we_data  = bus_we && (bus_addr == AW'(A_DATA));
   assign we_flag  = bus_we && (bus_addr == AW'(A_FLAG));
   assign we_ien   = bus_we && (bus_addr == AW'(A_IEN));
   assign we_ovf   = bus_we && (bus_addr == AW'(A_OVF));

   assign force_vec = we_force ? bus_wdata[NCH-1:0] : '0;
   assign master_ev = match_vec[MST] || force_vec[MST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         ovf_ie_q <= 1'b0;
         act_q    <= '0;
         mask_q   <= '0;
         data_q   <= '0;
         ien_q    <= '0;
      end else begin
         if (we_ctrl) begin
            run_q    <= bus_wdata[0];
            ovf_ie_q <= bus_wdata[1];
         end
         if (we_act)  act_q  <= bus_wdata[AW_ACT-1:0];
         if (we_mask) mask_q <= bus_wdata[MST-1:0];
         if (we_data) data_q <= bus_wdata[MST-1:0];
         if (we_ien)  ien_q  <= bus_wdata[NCH-1:0];
      end
   end

   oct_counter #(.CW(CW)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run_q),
      .load     (we_count),
      .load_val (bus_wdata[CW-1:0]),
      .ovf_clr  (we_ovf && bus_wdata[0]),
      .cnt_o    (cnt_q),
      .ovf_o    (ovf_q)
   );

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic ovr_en, ovr_val;
      if (n == MST) begin : g_master
         assign ovr_en  = 1'b0;
         assign ovr_val = 1'b0;
      end else begin : g_slave
         assign ovr_en  = master_ev && mask_q[n];
         assign ovr_val = data_q[n];
      end
      oct_channel #(.CW(CW)) u_ch (
         .clk      (clk),
         .rst_n    (rst_n),
         .cnt      (cnt_q),
         .run      (run_q),
         .cmp_we   (bus_we && (bus_addr == AW'(A_CMP_BASE) + AW'(n))),
         .cmp_wd   (bus_wdata[CW-1:0]),
         .act      (act_q[2*n +: 2]),
         .force_i  (force_vec[n]),
         .ovr_en   (ovr_en),
         .ovr_val  (ovr_val),
         .flag_clr (we_flag && bus_wdata[n]),
         .match_o  (match_vec[n]),
         .flag_o   (flag_vec[n]),
         .pin_o    (oc_pin[n]),
         .cmp_o    (cmp_arr[n])
      );
   end

   assign irq_cmp = |(flag_vec & ien_q);
   assign irq_ovf = ovf_q && ovf_ie_q;

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         AW'(A_CTRL):   bus_rdata = DW'({ovf_ie_q, run_q});
         AW'(A_COUNT):  bus_rdata = DW'(cnt_q);
         AW'(A_ACTION): bus_rdata = DW'(act_q);
         AW'(A_MASK):   bus_rdata = DW'(mask_q);
         AW'(A_DATA):   bus_rdata = DW'(data_q);
         AW'(A_FLAG):   bus_rdata = DW'(flag_vec);
         AW'(A_IEN):    bus_rdata = DW'(ien_q);
         AW'(A_OVF):    bus_rdata = DW'(ovf_q);
         default: begin
            for (int k = 0; k < NCH; k++) begin
               if (bus_addr == AW'(A_CMP_BASE) + AW'(k)) bus_rdata = DW'(cmp_arr[k]);
            end
         end
      endcase
   end
endmodule

// File: rtl/oct_checker.sv
module oct_checker #(
   parameter int NCH = 8,
   parameter int CW  = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           run,
   input logic           cnt_load,
   input logic [CW-1:0]  cnt,
   input logic           ovf,
   input logic [NCH-1:0] match,
   input logic [NCH-1:0] flags,
   input logic [NCH-1:0] pins,
   input logic [NCH-1:0] force_vec,
   input logic           master_ev,
   input logic [NCH-2:0] mask,
   input logic [NCH-2:0] data,
   input logic           irq_cmp
);
   localparam logic [CW-1:0] TOP = '1;

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run && !cnt_load |=> cnt == ($past(cnt) + CW'(1)));

   assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run && !cnt_load |=> $stable(cnt));

   assert_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      run && !cnt_load && cnt == TOP |=> ovf);

   // a flag may only rise after a match, never after a force (R5, R6)
   assert_flag_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((flags & ~$past(flags)) & ~$past(match)) == '0);

   assert_irq_has_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_cmp |-> (flags != '0));

   assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
      master_ev |=> ((pins[NCH-2:0] ^ $past(data)) & $past(mask)) == '0);

   assert_pins_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !run && force_vec == '0 |=> $stable(pins));
endmodule

bind oc_compare_timer oct_checker #(.NCH(NCH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .run       (run_q),
   .cnt_load  (we_count),
   .cnt       (cnt_q),
   .ovf       (ovf_q),
   .match     (match_vec),
   .flags     (flag_vec),
   .pins      (oc_pin),
   .force_vec (force_vec),
   .master_ev (master_ev),
   .mask      (mask_q),
   .data      (data_q),
   .irq_cmp   (irq_cmp)
);

// File: tb/sim_oc_compare_timer.sv
module sim_oc_compare_timer;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  oc_pin;
   logic        irq_cmp, irq_ovf;

   always #(CLK_PERIOD/2) clk = ~clk;

   oc_compare_timer u0 (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .oc_pin(oc_pin),
      .irq_cmp(irq_cmp), .irq_ovf(irq_ovf)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state, built from the requirements
   logic [15:0] m_cnt, m_act;
   logic [15:0] m_cmp [8];
   logic [6:0]  m_mask, m_data;
   logic [7:0]  m_flags, m_ien, m_pins;
   bit          m_run, m_ovie, m_ovf;

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   function automatic logic [15:0] model_rd(input logic [4:0] a);
      case (a)
         5'h00: return {14'b0, m_ovie, m_run};
         5'h01: return m_cnt;
         5'h02: return m_act;
         5'h04: return {9'b0, m_mask};
         5'h05: return {9'b0, m_data};
         5'h06: return {8'b0, m_flags};
         5'h07: return {8'b0, m_ien};
         5'h08: return {15'b0, m_ovf};
         default: return (a >= 5'h10 && a < 5'h18) ? m_cmp[a - 5'h10] : 16'h0;
      endcase
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_act = 0; m_mask = 0; m_data = 0; m_flags = 0;
      m_ien = 0; m_pins = 0; m_run = 0; m_ovie = 0; m_ovf = 0;
      for (int k = 0; k < 8; k++) m_cmp[k] = 0;
   endtask

   task automatic model_step(input bit we, input logic [4:0] a, input logic [15:0] d);
      logic [7:0] mt, fv, ev, np;
      for (int k = 0; k < 8; k++) mt[k] = m_run && (m_cnt == m_cmp[k]);
      fv = (we && a == 5'h03) ? d[7:0] : 8'h0;
      ev = mt | fv;
      np = m_pins;
      for (int k = 0; k < 8; k++) begin
         if (ev[k]) begin
            case (m_act[2*k +: 2])
               2'b01: np[k] = ~np[k];
               2'b10: np[k] = 1'b0;
               2'b11: np[k] = 1'b1;
               default: ;
            endcase
         end
      end
      if (ev[7]) for (int k = 0; k < 7; k++) if (m_mask[k]) np[k] = m_data[k];
      if (we && a == 5'h06) m_flags = m_flags & ~d[7:0];
      m_flags = m_flags | mt;
      if (we && a == 5'h08 && d[0]) m_ovf = 0;
      if (m_run && m_cnt == 16'hFFFF && !(we && a == 5'h01)) m_ovf = 1;
      if (we && a == 5'h01) m_cnt = d;
      else if (m_run) m_cnt = m_cnt + 16'd1;
      if (we) begin
         case (a)
            5'h00: begin m_run = d[0]; m_ovie = d[1]; end
            5'h02: m_act = d;
            5'h04: m_mask = d[6:0];
            5'h05: m_data = d[6:0];
            5'h07: m_ien = d[7:0];
            default: if (a >= 5'h10 && a < 5'h18) m_cmp[a - 5'h10] = d;
         endcase
      end
      m_pins = np;
   endtask

   // called at a falling edge: check outputs, drive one cycle, move to next falling edge
   task automatic cycle(input bit we, input logic [4:0] a, input logic [15:0] d);
      chk("R4 R7 R8 pins", oc_pin, m_pins);
      chk("R5 irq_cmp", irq_cmp, |(m_flags & m_ien));
      chk("R3 irq_ovf", irq_ovf, m_ovf & m_ovie);
      bus_we = we; bus_addr = a; bus_wdata = d;
      model_step(we, a, d);
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cycle(1'b0, 5'h00, 16'h0);
   endtask

   task automatic peek(input string tag, input logic [4:0] a);
      bus_we = 1'b0; bus_addr = a;
      #1;
      chk(tag, bus_rdata, model_rd(a));
   endtask

   initial begin
      void'($urandom(32'd24681));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 pins after reset", oc_pin, 8'h00);
      chk("R1 irq_cmp after reset", irq_cmp, 1'b0);
      chk("R1 irq_ovf after reset", irq_ovf, 1'b0);
      peek("R1 counter after reset", 5'h01);
      @(negedge clk);

      // R4/R5: channel 0 drives high on match at count 5
      cycle(1, 5'h10, 16'd5);
      cycle(1, 5'h02, 16'h0003);
      cycle(1, 5'h07, 16'h0001);
      cycle(1, 5'h00, 16'h0001);
      idle(8);
      chk("R4 channel 0 high after match", oc_pin[0], 1'b1);
      chk("R5 irq_cmp after match", irq_cmp, 1'b1);
      peek("R5 flag 0 readback", 5'h06);
      cycle(1, 5'h06, 16'h0001);
      chk("R5 irq_cmp after clear", irq_cmp, 1'b0);
      peek("R2 counter readback", 5'h01);

      // R3: wrap
      cycle(1, 5'h01, 16'hFFFE);
      cycle(1, 5'h00, 16'h0003);
      idle(2);
      chk("R3 irq_ovf after wrap", irq_ovf, 1'b1);
      peek("R3 overflow flag", 5'h08);
      cycle(1, 5'h08, 16'h0001);
      chk("R3 irq_ovf after clear", irq_ovf, 1'b0);

      // R6: force toggles channel 1 without a flag
      cycle(1, 5'h00, 16'h0000);
      cycle(1, 5'h06, 16'h00FF);
      cycle(1, 5'h02, 16'h0007);
      cycle(1, 5'h03, 16'h0002);
      chk("R6 forced toggle on pin 1", oc_pin[1], 1'b1);
      peek("R6 force leaves flags clear", 5'h06);
      chk("R6 flags literal", bus_rdata, 16'h0000);
      peek("R6 force register reads zero", 5'h03);
      chk("R6 force literal", bus_rdata, 16'h0000);

      // R7: master force drives masked pins
      cycle(1, 5'h04, 16'h000F);
      cycle(1, 5'h05, 16'h0005);
      cycle(1, 5'h03, 16'h0080);
      chk("R7 masked pins take data", oc_pin[3:0], 4'b0101);
      peek("R7 action register unchanged", 5'h02);
      chk("R7 action literal", bus_rdata, 16'h0007);

      // R8: channel 3 (high) and master (data 0) match together
      cycle(1, 5'h02, 16'h00C7);
      cycle(1, 5'h13, 16'h0040);
      cycle(1, 5'h17, 16'h0040);
      cycle(1, 5'h01, 16'h0040);
      cycle(1, 5'h00, 16'h0001);
      cycle(0, 5'h00, 16'h0000);
      chk("R8 master data wins on pin 3", oc_pin[3], 1'b0);
      peek("R8 both flags set", 5'h06);
      chk("R8 flags 3 and 7", bus_rdata & 16'h0088, 16'h0088);

      // R9: stopped counter sitting on a compare value
      cycle(1, 5'h00, 16'h0000);
      cycle(1, 5'h06, 16'h00FF);
      cycle(1, 5'h01, 16'd5);
      idle(4);
      peek("R9 no flags while stopped", 5'h06);
      chk("R9 flags literal", bus_rdata, 16'h0000);
      peek("R9 counter held", 5'h01);
      chk("R9 counter literal", bus_rdata, 16'd5);

      // random phase (R2 R4 R5 R6 R7 R10 against the model)
      for (int i = 0; i < 4000; i++) begin
         int idx;
         logic [4:0] a;
         logic [15:0] d;
         idx = $urandom_range(0, 16);
         a = (idx < 9) ? 5'(idx) : 5'(16 + idx - 9);
         if (a == 5'h01 || a >= 5'h10) d = 16'($urandom_range(0, 63));
         else if (a == 5'h00) d = {14'b0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 7) != 0)};
         else d = 16'($urandom);
         if ($urandom_range(0, 3) == 0) peek("R10 register readback", 5'($urandom_range(0, 23)));
         if ($urandom_range(0, 9) < 4) cycle(0, 5'h00, 16'h0);
         else cycle(1, a, d);
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule